// File: doc/BRIEF.md
# Aging-Adaptive Variable-Latency Hold Controller

This controller sits beside a bypassing array multiplier and decides, for every operand pair that reaches the multiplier, whether the product may be captured after one clock cycle or must be held for two. It counts the zero bits of one operand. Which operand it examines is fixed by a parameter: the multiplicand for a column-bypass array, or the multiplicator for a row-bypass array. A pattern with many zeros has short carry chains and is judged single-cycle. Any other pattern is stretched by driving the operand-register clock enable low for one cycle.

The result-capture stage reports timing errors on `err_in` before the next clock edge. If an operation predicted to be single-cycle is flagged, the controller holds the operands and runs the operation again over two cycles. A wear monitor counts these flagged operations over a fixed window of started operations. Once the count in one window passes a limit, the monitor latches. From then on, a pattern needs one more zero to be treated as single-cycle. The latch clears only on reset.

Top module: `vl_hold_ctrl`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `opreg_en` is 1 while `in_valid` is low. The single-cycle test starts with threshold `N_ZERO`.
- R2: A new operation whose examined operand has strictly more than the active threshold of zero bits, with `err_in` low, gives `opreg_en`=1 and `done`=1 in that same cycle, and `busy` stays 0.
- R3: A new operation with a zero count at or below the active threshold gives `opreg_en`=0 and `done`=0 in its first cycle. In the next cycle it gives `busy`=1, `opreg_en`=1 and `done`=1. `busy` is never high in two consecutive cycles.
- R4: With `OP_SEL`=0 the examined operand is `op_a`; with `OP_SEL`=1 it is `op_b`. The operand that is not examined has no effect on the latency.
- R5: When `err_in` is 1 during a new operation judged single-cycle, the cycle ends with `opreg_en`=0 and `done`=0. The next cycle re-executes the operation with `busy`=1, `opreg_en`=1 and `done`=1.
- R6: `err_in` is neither acted on nor counted when `in_valid` is low, in either cycle of an operation judged two-cycle, or in the second cycle of a re-execution.
- R7: When the number of counted errors in the current window exceeds `ERR_LIMIT`, every later operation is single-cycle only if its zero count is strictly greater than `N_ZERO`+1.
- R8: The count of started operations wraps every `WIN_OPS` operations, and the error count is cleared at each wrap. Errors in different windows never add up.
- R9: Once the stricter threshold is in force, it stays in force until reset, including across windows that have no errors.
- R10: With `in_valid` low and `busy` low, `opreg_en` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | W | Multiplicand currently presented to the array |
| op_b | input | W | Multiplicator currently presented to the array |
| in_valid | input | 1 | The operand registers hold an operation |
| err_in | input | 1 | Timing error flagged by the result-capture stage for the current cycle |
| opreg_en | output | 1 | Clock enable for the operand registers; 0 holds the operands |
| busy | output | 1 | Second cycle of a stretched or re-executed operation |
| done | output | 1 | The product is valid at the next clock edge |

## Verification
The bench builds the block with W=8, N_ZERO=3, WIN_OPS=8 and ERR_LIMIT=1, so that two counted errors are enough to switch thresholds. With these values, a window wrap is reached after only eight operations. An operand such as 0x0F, with four zeros, is single-cycle under the relaxed threshold and two-cycle under the strict one, so a single operand value shows the switch. A second instance built with `OP_SEL`=1 receives the same stimulus and shows that the examined operand moves from `op_a` to `op_b`.

// File: rtl/vl_hold_pkg.sv
package vl_hold_pkg;

    // which multiplier operand feeds the zero-count judges
    typedef enum logic {
        SEL_MCAND  = 1'b0,   // column-bypass array: multiplicand
        SEL_MPLIER = 1'b1    // row-bypass array: multiplicator
    } opsel_e;

    // registered control state of the hold sequencer
    typedef struct packed {
        logic hold;          // operation is in its second (held) cycle
    } hold_state_t;

endpackage

// File: rtl/vl_zero_judge.sv
module vl_zero_judge #(
    parameter int W      = 8,
    parameter int THRESH = 3
) (
    input  logic [W-1:0] op,
    output logic         one_cyc
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] zeros;

    always_comb begin
        zeros = '0;
        for (int i = 0; i < W; i++) begin
            zeros = zeros + CW'(!op[i]);
        end
    end

    assign one_cyc = (int'(zeros) > THRESH);

endmodule

// File: rtl/vl_wear_mon.sv
module vl_wear_mon #(
    parameter int WIN_OPS   = 16,
    parameter int ERR_LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic err_hit,
    output logic aged
);
    localparam int OCW = (WIN_OPS > 1) ? $clog2(WIN_OPS) : 1;
    localparam int ECW = $clog2(WIN_OPS + 1);

    typedef struct packed {
        logic [OCW-1:0] op_cnt;
        logic [ECW-1:0] err_cnt;
        logic           aged;
    } mon_t;

    mon_t mon_d, mon_q;
    logic [ECW-1:0] err_sum;

    always_comb begin
        mon_d   = mon_q;
        err_sum = mon_q.err_cnt + ECW'(err_hit);
        if (op_start) begin
            if (int'(err_sum) > ERR_LIMIT) begin
                mon_d.aged = 1'b1;
            end
            if (mon_q.op_cnt == OCW'(WIN_OPS - 1)) begin
                mon_d.op_cnt  = '0;
                mon_d.err_cnt = '0;
            end else begin
                mon_d.op_cnt  = mon_q.op_cnt + 1'b1;
                mon_d.err_cnt = err_sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign aged = mon_q.aged;

    AST_AGED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mon_q.aged |=> mon_q.aged); // R9

    AST_AGED_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mon_q.aged) |-> $past(op_start && err_hit)); // R7

    AST_ERR_LE_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mon_q.err_cnt) <= int'(mon_q.op_cnt)); // R8

endmodule

// File: rtl/vl_hold_ctrl.sv
module vl_hold_ctrl
    import vl_hold_pkg::*;
#(
    parameter int     W         = 8,
    parameter int     N_ZERO    = 3,
    parameter int     WIN_OPS   = 16,
    parameter int     ERR_LIMIT = 2,
    parameter opsel_e OP_SEL    = SEL_MCAND
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         in_valid,
    input  logic         err_in,
    output logic         opreg_en,
    output logic         busy,
    output logic         done
);
    localparam int NJ = 2;   // relaxed and strict judges

    hold_state_t st_d, st_q;
    logic [W-1:0]  op_exam;
    logic [NJ-1:0] judge_one;
    logic          aged;
    logic          sel_one;
    logic          op_start;
    logic          err_hit;
    logic          fast_ok;

    assign op_exam = (OP_SEL == SEL_MPLIER) ? op_b : op_a;

    for (genvar gi = 0; gi < NJ; gi++) begin : g_judge
        vl_zero_judge #(
            .W      (W),
            .THRESH (N_ZERO + gi)
        ) u_judge (
            .op      (op_exam),
            .one_cyc (judge_one[gi])
        );
    end

    vl_wear_mon #(
        .WIN_OPS   (WIN_OPS),
        .ERR_LIMIT (ERR_LIMIT)
    ) u_wear (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .err_hit  (err_hit),
        .aged     (aged)
    );

    always_comb begin
        st_d     = st_q;
        sel_one  = judge_one[aged];
        op_start = in_valid && !st_q.hold;
        fast_ok  = sel_one && !err_in;
        err_hit  = op_start && sel_one && err_in;
        st_d.hold = op_start && !fast_ok;
        opreg_en = !in_valid || st_q.hold || fast_ok;
        done     = st_q.hold || (op_start && fast_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.hold;

    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R3

    AST_STALL_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !opreg_en) |=> (busy && done && opreg_en)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !busy) |-> (opreg_en && !done)); // R10

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> opreg_en); // R2

endmodule

// File: tb/vl_hold_ctrl_tb.sv
module vl_hold_ctrl_tb;
    import vl_hold_pkg::*;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         in_valid = 1'b0;
    logic         err_in = 1'b0;
    logic         opreg_en, busy, done;
    logic         mr_en, mr_busy, mr_done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 4 ns period

    vl_hold_ctrl #(.W(W), .N_ZERO(3), .WIN_OPS(8), .ERR_LIMIT(1), .OP_SEL(SEL_MCAND)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .in_valid(in_valid),
        .err_in(err_in), .opreg_en(opreg_en), .busy(busy), .done(done));

    vl_hold_ctrl #(.W(W), .N_ZERO(3), .WIN_OPS(8), .ERR_LIMIT(1), .OP_SEL(SEL_MPLIER)) u_dut_mr (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .in_valid(in_valid),
        .err_in(err_in), .opreg_en(mr_en), .busy(mr_busy), .done(mr_done));

    // vector: {valid, a[7:0], b[7:0], err, exp_en, exp_done, exp_busy}
    localparam int NV = 13;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'h00, 1'b0, 3'b100},  // R10 idle
        {1'b0, 8'h00, 8'h00, 1'b1, 3'b100},  // R6 idle error ignored
        {1'b1, 8'h0F, 8'hFF, 1'b0, 3'b110},  // R2 four zeros
        {1'b1, 8'h1F, 8'hFF, 1'b0, 3'b000},  // R3 three zeros, first cycle
        {1'b1, 8'h1F, 8'hFF, 1'b0, 3'b111},  // R3 held cycle
        {1'b1, 8'h00, 8'hFF, 1'b0, 3'b110},  // R4 op_b ignored
        {1'b1, 8'hFF, 8'h00, 1'b1, 3'b000},  // R4 R6 two-cycle, error ignored
        {1'b1, 8'hFF, 8'h00, 1'b1, 3'b111},  // R6 held cycle error ignored
        {1'b1, 8'h0F, 8'hFF, 1'b1, 3'b000},  // R5 error on fast op
        {1'b1, 8'h0F, 8'hFF, 1'b1, 3'b111},  // R5 re-execution
        {1'b1, 8'h07, 8'hFF, 1'b0, 3'b110},  // R2 five zeros
        {1'b1, 8'h0F, 8'hFF, 1'b0, 3'b110},  // R6 only one error counted
        {1'b0, 8'h00, 8'h00, 1'b0, 3'b100}   // R10 idle
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic [W-1:0] a, input logic [W-1:0] b, input logic e);
        @(negedge clk);
        in_valid = v; op_a = a; op_b = b; err_in = e;
        #1;
    endtask

    task automatic step(input string req, input logic v, input logic [W-1:0] a,
                        input logic e, input logic x_en, input logic x_done, input logic x_busy);
        drive(v, a, 8'hFF, e);
        chk({req, " opreg_en"}, opreg_en, x_en);
        chk({req, " done"}, done, x_done);
        chk({req, " busy"}, busy, x_busy);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; err_in = 1'b0; op_a = '0; op_b = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        #1;
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        chk("R1 opreg_en", opreg_en, 1'b1);

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][20], VEC[i][19:12], VEC[i][11:4], VEC[i][3]);
            chk($sformatf("vec%0d opreg_en", i), opreg_en, VEC[i][2]);
            chk($sformatf("vec%0d done", i), done, VEC[i][1]);
            chk($sformatf("vec%0d busy", i), busy, VEC[i][0]);
        end

        // R4: multiplicator-examining variant
        do_reset();
        drive(1'b1, 8'hFF, 8'h0F, 1'b0);
        chk("R4 mcand variant stalls", opreg_en, 1'b0);
        chk("R4 mplier variant en", mr_en, 1'b1);
        chk("R4 mplier variant done", mr_done, 1'b1);
        drive(1'b1, 8'hFF, 8'h0F, 1'b0);
        chk("R4 mcand variant held done", done, 1'b1);
        drive(1'b0, 8'h00, 8'h00, 1'b0);

        // R7, R9: two errors in one window tighten the threshold
        do_reset();
        step("R5 err1", 1'b1, 8'h0F, 1'b1, 1'b0, 1'b0, 1'b0);
        step("R5 redo1", 1'b1, 8'h0F, 1'b1, 1'b1, 1'b1, 1'b1);
        step("R5 err2", 1'b1, 8'h0F, 1'b1, 1'b0, 1'b0, 1'b0);
        step("R5 redo2", 1'b1, 8'h0F, 1'b1, 1'b1, 1'b1, 1'b1);
        step("R7 four zeros now slow", 1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R7 held", 1'b1, 8'h0F, 1'b0, 1'b1, 1'b1, 1'b1);
        step("R7 five zeros fast", 1'b1, 8'h07, 1'b0, 1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 20; k++) begin
            drive(1'b1, 8'h00, 8'hFF, 1'b0);
            chk("R9 clean op done", done, 1'b1);
        end
        step("R9 still strict", 1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R9 held", 1'b1, 8'h0F, 1'b0, 1'b1, 1'b1, 1'b1);

        // R8: errors in separate windows do not accumulate
        do_reset();
        step("R8 err win0", 1'b1, 8'h0F, 1'b1, 1'b0, 1'b0, 1'b0);
        step("R8 redo win0", 1'b1, 8'h0F, 1'b0, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 7; k++) begin
            drive(1'b1, 8'h00, 8'hFF, 1'b0);
            chk("R8 fill window", done, 1'b1);
        end
        step("R8 err win1", 1'b1, 8'h0F, 1'b1, 1'b0, 1'b0, 1'b0);
        step("R8 redo win1", 1'b1, 8'h0F, 1'b0, 1'b1, 1'b1, 1'b1);
        step("R8 still relaxed", 1'b1, 8'h0F, 1'b0, 1'b1, 1'b1, 1'b0);
        step("R10 idle", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule